// File: doc/BRIEF.md
# Wrapped Cache Line Fill Buffer

This block services one cache miss at a time by pulling the missing line over a memory bus that is narrower than the line. It asks memory for a wrapping burst that begins with the bus-wide chunk holding the missed byte. The remaining chunks follow in ascending order and wrap back to the start of the line. The first chunk is handed to the core in the same cycle it arrives, together with the byte offset of the miss inside that chunk, so the core can restart before the line is complete.

Each chunk is written into its own slot of a line-wide buffer, chosen by its position in the line and not by its arrival order. Once the last chunk is in, the whole line is written into the cache in one cycle, together with its line-aligned address. While a fill is in progress, new misses are held off. With the default parameters the bus is 8 bytes and the line is 32 bytes, so a fill takes 4 beats.

Top module: `cwf_fill_top`

## Requirements
- R1: After reset, `miss_ready_o` is 1 and `mem_req_valid_o`, `fwd_valid_o` and `line_wr_o` are 0.
- R2: In the cycle after a miss is accepted (`miss_valid_i` and `miss_ready_o` both high at a clock edge), `mem_req_valid_o` rises. `mem_req_addr_o` then equals the miss address with its low 3 bits cleared, and `mem_req_beats_o` equals 4. Both stay stable until `mem_req_ready_i` is high at a clock edge.
- R3: `miss_ready_o` is 0 from the cycle after a miss is accepted until the cycle after `line_wr_o`. A `miss_valid_i` raised during that time starts no request.
- R4: The first data beat after the request handshake is forwarded in the same cycle. `fwd_valid_o` is 1, `fwd_data_o` equals `mem_data_i`, and `fwd_offset_o` equals bits [2:0] of the miss address. `fwd_valid_o` is asserted exactly once per fill.
- R5: Beat n of a fill (n = 0..3, counting only cycles with `mem_data_valid_i` high) lands in chunk slot (s + n) mod 4, where s is bits [4:3] of the miss address. Slot i occupies bits [64i+63:64i] of `line_data_o`, which hold line bytes 8i..8i+7.
- R6: `line_wr_o` is a single-cycle pulse in the cycle after the fourth beat is taken. `line_addr_o` then equals the miss address with its low 5 bits cleared.
- R7: `mem_data_valid_i` is ignored outside the data phase of a fill. Cycles with `mem_data_valid_i` low in the middle of a fill only delay it.
- R8: A miss in the first chunk (s = 0) fills in plain order without a wrap, and a miss in the last chunk (s = 3) wraps after its first beat. Both produce the line laid out as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| miss_valid_i | input | 1 | Miss request present |
| miss_addr_i | input | 32 | Byte address of the miss |
| miss_ready_o | output | 1 | Block idle, miss can be taken |
| mem_req_valid_o | output | 1 | Burst request to memory pending |
| mem_req_addr_o | output | 32 | Address of the first chunk of the burst (chunk aligned) |
| mem_req_beats_o | output | 3 | Beats in the wrapping burst |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_data_valid_i | input | 1 | Data beat present on the bus |
| mem_data_i | input | 64 | Data beat |
| fwd_valid_o | output | 1 | Critical chunk forwarded to the core |
| fwd_data_o | output | 64 | Critical chunk |
| fwd_offset_o | output | 3 | Byte offset of the miss within the critical chunk |
| line_wr_o | output | 1 | Write the complete line into the cache |
| line_addr_o | output | 32 | Line-aligned address of the written line |
| line_data_o | output | 256 | Complete line, slot i at bits [64i+63:64i] |

## Verification
The checks assume that memory drives data beats only after it has taken the burst request, and that it returns exactly four beats per request. They also assume `mem_req_ready_i` is raised only while a request is pending. The bench plays memory and keeps to these rules. It raises the ready only after it sees `mem_req_valid_o` and drops it after one edge, and it counts out exactly four valid beats, with optional idle cycles between them. It also drives a stray data beat while idle and a second miss during a fill, to check that both are ignored.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_FILL  = 2'd2,
    ST_WRITE = 2'd3
  } fill_st_e;
endpackage

// File: rtl/cwf_addr_split.sv
module cwf_addr_split #(
  parameter int ADDR_W  = 32,
  parameter int CHUNK_W = 3,
  parameter int OFS_W   = 5
) (
  input  logic [ADDR_W-1:0]        addr_i,
  output logic [OFS_W-CHUNK_W-1:0] start_idx_o,
  output logic [CHUNK_W-1:0]       byte_ofs_o,
  output logic [ADDR_W-1:0]        chunk_addr_o,
  output logic [ADDR_W-1:0]        line_addr_o
);
  assign byte_ofs_o   = addr_i[CHUNK_W-1:0];
  assign start_idx_o  = addr_i[OFS_W-1:CHUNK_W];
  assign chunk_addr_o = {addr_i[ADDR_W-1:CHUNK_W], {CHUNK_W{1'b0}}};
  assign line_addr_o  = {addr_i[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
endmodule

// File: rtl/cwf_fill_ctrl.sv
module cwf_fill_ctrl
  import cwf_pkg::*;
#(
  parameter int NCHUNK = 4,
  parameter int IDX_W  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             miss_valid_i,
  input  logic             mem_req_ready_i,
  input  logic             mem_data_valid_i,
  output fill_st_e         state_o,
  output logic [IDX_W-1:0] beat_cnt_o,
  output logic             beat_we_o
);
  fill_st_e         state_q;
  logic [IDX_W-1:0] cnt_q;

  assign beat_we_o  = (state_q == ST_FILL) && mem_data_valid_i;
  assign state_o    = state_q;
  assign beat_cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (miss_valid_i) state_q <= ST_REQ;
        ST_REQ: begin
          cnt_q <= '0;
          if (mem_req_ready_i) state_q <= ST_FILL;
        end
        ST_FILL: begin
          if (mem_data_valid_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == IDX_W'(NCHUNK-1)) state_q <= ST_WRITE;
          end
        end
        ST_WRITE: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cwf_line_buf.sv
module cwf_line_buf #(
  parameter int NCHUNK = 4,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 64
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [IDX_W-1:0]         idx_i,
  input  logic [DATA_W-1:0]        data_i,
  output logic [NCHUNK*DATA_W-1:0] line_o
);
  for (genvar g = 0; g < NCHUNK; g++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            slot_q <= '0;
      else if (we_i && idx_i == IDX_W'(g))    slot_q <= data_i;
    end
    assign line_o[g*DATA_W +: DATA_W] = slot_q;
  end
endmodule

// File: rtl/cwf_fill_top.sv
module cwf_fill_top
  import cwf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BUS_BYTES  = 8,
  parameter int LINE_BYTES = 32,
  localparam int DATA_W    = BUS_BYTES * 8,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int NCHUNK    = LINE_BYTES / BUS_BYTES,
  localparam int CHUNK_W   = $clog2(BUS_BYTES),
  localparam int OFS_W     = $clog2(LINE_BYTES),
  localparam int IDX_W     = OFS_W - CHUNK_W,
  localparam int BEATS_W   = $clog2(NCHUNK + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               miss_valid_i,
  input  logic [ADDR_W-1:0]  miss_addr_i,
  output logic               miss_ready_o,
  output logic               mem_req_valid_o,
  output logic [ADDR_W-1:0]  mem_req_addr_o,
  output logic [BEATS_W-1:0] mem_req_beats_o,
  input  logic               mem_req_ready_i,
  input  logic               mem_data_valid_i,
  input  logic [DATA_W-1:0]  mem_data_i,
  output logic               fwd_valid_o,
  output logic [DATA_W-1:0]  fwd_data_o,
  output logic [CHUNK_W-1:0] fwd_offset_o,
  output logic               line_wr_o,
  output logic [ADDR_W-1:0]  line_addr_o,
  output logic [LINE_W-1:0]  line_data_o
);
  fill_st_e          state;
  logic [IDX_W-1:0]  beat_cnt;
  logic [IDX_W-1:0]  start_idx;
  logic              beat_we;
  logic [ADDR_W-1:0] miss_addr_q;

  assign miss_ready_o = (state == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          miss_addr_q <= '0;
    else if (miss_valid_i && miss_ready_o) miss_addr_q <= miss_addr_i;
  end

  cwf_addr_split #(
    .ADDR_W (ADDR_W),
    .CHUNK_W(CHUNK_W),
    .OFS_W  (OFS_W)
  ) u_split (
    .addr_i      (miss_addr_q),
    .start_idx_o (start_idx),
    .byte_ofs_o  (fwd_offset_o),
    .chunk_addr_o(mem_req_addr_o),
    .line_addr_o (line_addr_o)
  );

  cwf_fill_ctrl #(
    .NCHUNK(NCHUNK),
    .IDX_W (IDX_W)
  ) u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .miss_valid_i    (miss_valid_i),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_data_valid_i(mem_data_valid_i),
    .state_o         (state),
    .beat_cnt_o      (beat_cnt),
    .beat_we_o       (beat_we)
  );

  // slot index wraps through the line because NCHUNK is a power of two
  cwf_line_buf #(
    .NCHUNK(NCHUNK),
    .IDX_W (IDX_W),
    .DATA_W(DATA_W)
  ) u_buf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (beat_we),
    .idx_i (start_idx + beat_cnt),
    .data_i(mem_data_i),
    .line_o(line_data_o)
  );

  assign mem_req_valid_o = (state == ST_REQ);
  assign mem_req_beats_o = BEATS_W'(NCHUNK);
  // early restart: critical beat bypasses the buffer
  assign fwd_valid_o     = beat_we && (beat_cnt == '0);
  assign fwd_data_o      = mem_data_i;
  assign line_wr_o       = (state == ST_WRITE);
endmodule

// File: rtl/cwf_fill_chk.sv
module cwf_fill_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              miss_valid_i,
  input logic              miss_ready_o,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic [ADDR_W-1:0] mem_req_addr_o,
  input logic              fwd_valid_o,
  input logic              line_wr_o
);
  logic fwd_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           fwd_seen_q <= 1'b0;
    else if (miss_valid_i && miss_ready_o) fwd_seen_q <= 1'b0;
    else if (fwd_valid_o)                  fwd_seen_q <= 1'b1;
  end

  AST_RESET_IDLE: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> miss_ready_o && !mem_req_valid_o && !line_wr_o); // R1
  AST_REQ_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_valid_i && miss_ready_o |=> mem_req_valid_o); // R2
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o)); // R2
  AST_BUSY_NO_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o || fwd_valid_o || line_wr_o) |-> !miss_ready_o); // R3
  AST_FWD_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> !fwd_seen_q); // R4
  AST_LINE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_wr_o |=> !line_wr_o && miss_ready_o); // R6
  AST_PHASES_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_req_valid_o, fwd_valid_o, line_wr_o})); // R7
endmodule

bind cwf_fill_top cwf_fill_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .miss_valid_i   (miss_valid_i),
  .miss_ready_o   (miss_ready_o),
  .mem_req_valid_o(mem_req_valid_o),
  .mem_req_ready_i(mem_req_ready_i),
  .mem_req_addr_o (mem_req_addr_o),
  .fwd_valid_o    (fwd_valid_o),
  .line_wr_o      (line_wr_o)
);

// File: tb/cwf_fill_top_test.sv
module cwf_fill_top_test;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         miss_valid_i = 1'b0;
  logic [31:0]  miss_addr_i = '0;
  logic         miss_ready_o;
  logic         mem_req_valid_o;
  logic [31:0]  mem_req_addr_o;
  logic [2:0]   mem_req_beats_o;
  logic         mem_req_ready_i = 1'b0;
  logic         mem_data_valid_i = 1'b0;
  logic [63:0]  mem_data_i = '0;
  logic         fwd_valid_o;
  logic [63:0]  fwd_data_o;
  logic [2:0]   fwd_offset_o;
  logic         line_wr_o;
  logic [31:0]  line_addr_o;
  logic [255:0] line_data_o;

  always #10 clk_i = ~clk_i;

  cwf_fill_top uut (.*);

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [63:0]  exp_fwd_q[$];
  logic [2:0]   exp_ofs_q[$];
  logic [31:0]  exp_laddr_q[$];
  logic [255:0] exp_line_q[$];

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] chunk_val(input logic [31:0] base, input int idx, input int seed);
    return {base + 32'(8 * idx), 32'h5A00_0000 + 32'(seed * 16 + idx)};
  endfunction

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (fwd_valid_o) begin
        if (exp_fwd_q.size() == 0) chk(1'b0, "R7 unexpected forward", 256'(fwd_data_o), '0);
        else begin
          logic [63:0] ed;
          logic [2:0]  eo;
          ed = exp_fwd_q.pop_front();
          eo = exp_ofs_q.pop_front();
          chk(fwd_data_o == ed, "R4 forward data", 256'(fwd_data_o), 256'(ed));
          chk(fwd_offset_o == eo, "R4 forward offset", 256'(fwd_offset_o), 256'(eo));
        end
      end
      if (line_wr_o) begin
        if (exp_line_q.size() == 0) chk(1'b0, "R6 unexpected line write", line_data_o, '0);
        else begin
          logic [31:0]  ea;
          logic [255:0] el;
          ea = exp_laddr_q.pop_front();
          el = exp_line_q.pop_front();
          chk(line_addr_o == ea, "R6 line address", 256'(line_addr_o), 256'(ea));
          chk(line_data_o == el, "R5 R8 line data", line_data_o, el);
        end
      end
    end
  end

  task automatic do_fill(input logic [31:0] a, input int req_delay, input int gap,
                         input bit spur, input int seed);
    logic [31:0]  base;
    logic [255:0] line;
    int           s;
    base = {a[31:5], 5'b0};
    s    = int'(a[4:3]);
    for (int i = 0; i < 4; i++) line[i*64 +: 64] = chunk_val(base, i, seed);
    exp_fwd_q.push_back(chunk_val(base, s, seed));
    exp_ofs_q.push_back(a[2:0]);
    exp_laddr_q.push_back(base);
    exp_line_q.push_back(line);

    @(posedge clk_i); #1;
    miss_valid_i = 1'b1; miss_addr_i = a;
    @(posedge clk_i); #1;
    miss_valid_i = spur; miss_addr_i = a ^ 32'h400;
    @(negedge clk_i);
    chk(mem_req_valid_o, "R2 request raised", 256'(mem_req_valid_o), 256'(1));
    chk(mem_req_addr_o == {a[31:3], 3'b0}, "R2 request address", 256'(mem_req_addr_o), 256'({a[31:3], 3'b0}));
    chk(mem_req_beats_o == 3'd4, "R2 beats", 256'(mem_req_beats_o), 256'(4));
    chk(!miss_ready_o, "R3 busy", 256'(miss_ready_o), 256'(0));
    for (int d = 0; d < req_delay; d++) begin
      @(negedge clk_i);
      chk(mem_req_valid_o && mem_req_addr_o == {a[31:3], 3'b0}, "R2 request held",
          256'(mem_req_addr_o), 256'({a[31:3], 3'b0}));
    end
    mem_req_ready_i = 1'b1;
    @(posedge clk_i); #1;
    mem_req_ready_i = 1'b0;
    for (int n = 0; n < 4; n++) begin
      for (int g = 0; g < gap; g++) begin
        @(posedge clk_i); #1;
      end
      mem_data_valid_i = 1'b1;
      mem_data_i = chunk_val(base, (s + n) % 4, seed);
      if (n == 3) miss_valid_i = 1'b0;
      if (n == 1) begin
        @(negedge clk_i);
        chk(!miss_ready_o, "R3 busy in fill", 256'(miss_ready_o), 256'(0));
      end
      @(posedge clk_i); #1;
      mem_data_valid_i = 1'b0;
      mem_data_i = 64'hDEAD_BEEF_DEAD_BEEF;
    end
    @(posedge clk_i);
    @(negedge clk_i);
    chk(miss_ready_o && !mem_req_valid_o, "R3 idle after write, stray miss ignored",
        256'({miss_ready_o, mem_req_valid_o}), 256'(2'b10));
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(miss_ready_o, "R1 ready", 256'(miss_ready_o), 256'(1));
    chk(!mem_req_valid_o, "R1 no request", 256'(mem_req_valid_o), 256'(0));
    chk(!fwd_valid_o, "R1 no forward", 256'(fwd_valid_o), 256'(0));
    chk(!line_wr_o, "R1 no line write", 256'(line_wr_o), 256'(0));

    // R7: stray beat while idle
    @(posedge clk_i); #1;
    mem_data_valid_i = 1'b1; mem_data_i = 64'h1111_2222_3333_4444;
    @(negedge clk_i);
    chk(!fwd_valid_o && miss_ready_o, "R7 idle beat ignored", 256'(fwd_valid_o), 256'(0));
    @(posedge clk_i); #1;
    mem_data_valid_i = 1'b0;

    do_fill(32'h0000_0095, 0, 0, 1'b0, 1);  // wrap from slot 2
    do_fill(32'h0000_0080, 2, 0, 1'b0, 2);  // R8 slot 0, no wrap
    do_fill(32'h0000_01FF, 0, 1, 1'b1, 3);  // R8 slot 3, gaps, stray miss
    do_fill(32'h1234_5678, 3, 2, 1'b1, 4);  // R7 gaps mid fill
    do_fill(32'hFFFF_FFE9, 1, 0, 1'b0, 5);

    repeat (4) @(posedge clk_i);
    @(negedge clk_i);
    chk(exp_fwd_q.size() == 0, "R4 all forwards seen", 256'(exp_fwd_q.size()), 256'(0));
    chk(exp_line_q.size() == 0, "R6 all line writes seen", 256'(exp_line_q.size()), 256'(0));
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule